// File: doc/BRIEF.md
# Security event rate limiter

This block enforces a usage profile on the protected operations of a security controller. It holds an 8-bit score that only saturates, never wraps. The score rises by one for each admitted operation. It also rises by one for each cycle that one of four protected-use strobes is high. Each strobe stands for one kind of event:
- a failed decrypt or integrity check during a protected update;
- a key derived from a persistent object;
- use of an on-chip private key;
- use of an on-chip secret key.

A fifth strobe reports behaviour that does not fit the system's expected state. That event is never permitted, and it drives the score straight to its ceiling.

A free-running timer splits time into policy windows of `PERIOD_CYC` clock cycles. The default is 5 s at a 50 MHz clock. At the last cycle of each window the score drops by one if it is nonzero. This drain is background idle work, and `idle_busy` tells the power controller to delay sleep entry while the drain is still running.

Requests to start a protected operation arrive on a valid/ready pair. A request is admitted at once while the score is zero. Otherwise it is held back until the next window boundary. The result is that, in steady state, at most one operation is admitted per window.

Back-pressure rules:
- Once `req_valid` is raised, the requester keeps it high until it sees `req_ready` high in the same cycle.
- `req_ready` is a combinational, single-cycle acceptance. It is never high while `req_valid` is low.

Top module: `sev_throttle`

## Requirements
- R1: During and right after reset, `sec_count` is 0, `idle_busy` is 0 and `req_ready` is 0 while `req_valid` is 0.
- R2: On each clock edge, the score grows by the number of protected strobes high in that cycle, plus one if a request is accepted in that cycle. The result is clamped at 255 and never wraps.
- R3: If `ev_suspect` is high in a cycle, the score becomes 255 at the next edge, whatever the other inputs do.
- R4: The cycle where (cycles since reset release) mod `PERIOD_CYC` equals `PERIOD_CYC`-1 is a window boundary; the first cycle after release counts as 0. At a boundary with a nonzero score, 1 is subtracted together with that cycle's additions, and the result is again clamped at 255.
- R5: While the score is zero, a valid request is accepted in the same cycle.
- R6: While the score is nonzero, a valid request is accepted only in a boundary cycle. `req_ready` is never high without `req_valid`.
- R7: `idle_busy` is high exactly when the score is nonzero.
- R8: With `req_valid` held high continuously and no other events, 500 back-to-back operations are accepted. After the first acceptance, consecutive acceptances are exactly `PERIOD_CYC` cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_decrypt_fail | input | 1 | Protected update failed its decrypt or integrity check |
| ev_key_derive | input | 1 | Key derived from a persistent object |
| ev_priv_key | input | 1 | On-chip private key used |
| ev_secret_key | input | 1 | On-chip secret key used |
| ev_suspect | input | 1 | Inconsistent system behaviour detected; saturates the score |
| req_valid | input | 1 | Request to start a protected operation |
| req_ready | output | 1 | Request accepted this cycle |
| idle_busy | output | 1 | Score drain still running; sleep entry must wait |
| sec_count | output | 8 | Current score |

## Verification
A wrong score shows on `sec_count` and `idle_busy` at the very next edge. A score that is wrong in its zero/nonzero sense also flips `req_ready` within the same cycle. A timer phase error shows up only at the next window boundary, either as a missed or extra decrement or as a grant in the wrong cycle. The long run of back-to-back requests therefore checks that grant spacing stays exactly one window over hundreds of periods, which would expose slow drift or a carry mistake in the timer.

// File: rtl/sev_pkg.sv
package sev_pkg;
  localparam int SEV_NUM_PROT = 4;
  localparam int SEV_CNT_W    = 8;

  typedef logic [SEV_NUM_PROT-1:0] prot_ev_t;

  function automatic int tally_width(input int n_inputs);
    return $clog2(n_inputs + 2);
  endfunction
endpackage

// File: rtl/sev_period_timer.sv
module sev_period_timer #(
  parameter int PERIOD_CYC = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         tmr_q <= '0;
    else if (tmr_q == LAST) tmr_q <= '0;
    else                tmr_q <= tmr_q + 1'b1;
  end

  assign tick = (tmr_q == LAST);

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R4
endmodule

// File: rtl/sev_event_tally.sv
module sev_event_tally #(
  parameter int N_IN    = 4,
  parameter int TALLY_W = 3
) (
  input  logic [N_IN-1:0]    ev,
  input  logic               accept,
  output logic [TALLY_W-1:0] tally
);
  logic [N_IN:0] bits;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
      assign bits[i] = ev[i];
    end
  endgenerate
  assign bits[N_IN] = accept;

  always_comb begin
    tally = '0;
    for (int i = 0; i <= N_IN; i++) tally = tally + TALLY_W'(bits[i]);
  end
endmodule

// File: rtl/sev_score.sv
module sev_score #(
  parameter int CNT_W   = 8,
  parameter int TALLY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TALLY_W-1:0] add,
  input  logic               boundary,
  input  logic               suspect,
  output logic [CNT_W-1:0]   cnt
);
  localparam int WW = CNT_W + TALLY_W + 1;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             dec;
  logic [WW-1:0]    wide;
  logic [CNT_W-1:0] cnt_d;

  assign dec = boundary && (cnt_q != '0);

  always_comb begin
    wide = WW'(cnt_q) + WW'(add) - WW'(dec);
    if (suspect)               cnt_d = MAXV;
    else if (wide > WW'(MAXV)) cnt_d = MAXV;
    else                       cnt_d = wide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_SUSPECT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    suspect |=> (cnt_q == MAXV)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !boundary) |=> (cnt_q == MAXV)); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cnt_q != '0 && add == '0 && !suspect)
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R4
endmodule

// File: rtl/sev_admit.sv
module sev_admit (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic score_zero,
  input  logic boundary,
  output logic req_ready
);
  assign req_ready = req_valid && (score_zero || boundary);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !score_zero && !boundary) |-> !req_ready); // R6
  AST_ZERO_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && score_zero) |-> req_ready); // R5
endmodule

// File: rtl/sev_throttle.sv
module sev_throttle #(
  parameter int PERIOD_CYC = 250_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_decrypt_fail,
  input  logic       ev_key_derive,
  input  logic       ev_priv_key,
  input  logic       ev_secret_key,
  input  logic       ev_suspect,
  input  logic       req_valid,
  output logic       req_ready,
  output logic       idle_busy,
  output logic [7:0] sec_count
);
  import sev_pkg::*;

  localparam int TALLY_W = tally_width(SEV_NUM_PROT);

  prot_ev_t               prot;
  logic                   tick;
  logic [TALLY_W-1:0]     tally;
  logic [SEV_CNT_W-1:0]   score;
  logic                   accept;

  assign prot = {ev_secret_key, ev_priv_key, ev_key_derive, ev_decrypt_fail};

  sev_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  sev_event_tally #(.N_IN(SEV_NUM_PROT), .TALLY_W(TALLY_W)) u_tally (
    .ev (prot), .accept (accept), .tally (tally)
  );

  sev_score #(.CNT_W(SEV_CNT_W), .TALLY_W(TALLY_W)) u_score (
    .clk (clk), .rst_n (rst_n), .add (tally), .boundary (tick),
    .suspect (ev_suspect), .cnt (score)
  );

  sev_admit u_admit (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
    .score_zero (score == '0), .boundary (tick), .req_ready (accept)
  );

  assign req_ready = accept;
  assign idle_busy = (score != '0);
  assign sec_count = score;

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_busy) |-> $past(tick)); // R7
  AST_READY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid); // R6
endmodule

// File: tb/sim_sev_throttle.sv
module sim_sev_throttle;
  localparam int P = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ev_decrypt_fail, ev_key_derive, ev_priv_key, ev_secret_key;
  logic ev_suspect, req_valid, req_ready, idle_busy;
  logic [7:0] sec_count;

  sev_throttle #(.PERIOD_CYC(P)) u0 (
    .clk (clk), .rst_n (rst_n), .ev_decrypt_fail (ev_decrypt_fail),
    .ev_key_derive (ev_key_derive), .ev_priv_key (ev_priv_key),
    .ev_secret_key (ev_secret_key), .ev_suspect (ev_suspect),
    .req_valid (req_valid), .req_ready (req_ready),
    .idle_busy (idle_busy), .sec_count (sec_count)
  );

  int checks = 0, fails = 0;
  int mcnt = 0, mcyc = 0;
  bit pending = 0, granted = 0, done = 0;
  string cnt_tag = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int next_score(input int cur, input int n, input bit tick, input bit sus);
    int w;
    if (sus) return 255;
    w = cur + n - ((tick && cur != 0) ? 1 : 0);
    return (w > 255) ? 255 : w;
  endfunction

  // Called at a negedge; returns at the next negedge.
  task automatic step(input logic [3:0] ev, input bit sus, input bit want);
    bit tick, exp_rdy;
    pending = pending | want;
    {ev_secret_key, ev_priv_key, ev_key_derive, ev_decrypt_fail} = ev;
    ev_suspect = sus;
    req_valid  = pending;
    #1;
    tick    = (mcyc % P) == P - 1;
    exp_rdy = pending && (mcnt == 0 || tick);
    chk(cnt_tag, sec_count, mcnt);
    chk("R7 busy", idle_busy, (mcnt != 0));
    chk(mcnt == 0 ? "R5 ready" : "R6 ready", req_ready, exp_rdy);
    granted = req_ready;
    if (req_ready) pending = 0;
    cnt_tag = sus ? "R3 count" : (tick ? "R4 count" : "R2 count");
    mcnt = next_score(mcnt, $countones(ev) + int'(exp_rdy), tick, sus);
    mcyc++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (mcnt != 0) step(4'h0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    int first_g, last_g, nres;
    rst_n = 0; ev_decrypt_fail = 0; ev_key_derive = 0; ev_priv_key = 0;
    ev_secret_key = 0; ev_suspect = 0; req_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset count", sec_count, 0);
    chk("R1 reset busy", idle_busy, 0);
    chk("R1 reset ready", req_ready, 0);
    rst_n = 1;
    s = $urandom(32'd20240611);

    // random traffic: R2..R7 checked each cycle
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ev;
      for (int b = 0; b < 4; b++) ev[b] = ($urandom % 8) == 0;
      step(ev, ($urandom % 500) == 0, ($urandom % 4) == 0);
    end
    while (pending) step(4'h0, 0, 0);
    drain();

    // R2: saturation with all four strobes held
    for (int i = 0; i < 90; i++) step(4'hF, 0, 0);
    chk("R2 saturated", sec_count, 255);
    drain();
    chk("R4 drained", sec_count, 0);

    // R3: suspect from zero alongside other strobes
    step(4'hA, 1, 0);
    chk("R3 suspect max", sec_count, 255);
    drain();

    // R5 then R8: held request, 500 acceptances
    nres = 0; first_g = -1; last_g = -1;
    while (nres < 500) begin
      int c;
      c = mcyc;
      step(4'h0, 0, 1);
      if (granted) begin
        if (nres == 0) chk("R5 immediate grant", c, first_g < 0 ? c : first_g);
        if (nres >= 2) chk("R8 grant spacing", c - last_g, P);
        if (nres == 0) first_g = c;
        last_g = c;
        nres++;
      end
    end
    chk("R8 grants", nres, 500);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule